// File: doc/BRIEF.md
# Encoded-Ratio System Clock Divider

This block takes one fast input clock and derives four slower timing domains from it: a CPU domain, a high-speed bus domain, a low-speed bus domain and a memory domain. Each domain is delivered as a clock-enable pulse, one input cycle wide. Downstream logic runs on the fast clock and qualifies its registers with the matching enable. A domain's divide factor is not written as a binary number. It is selected by a 4-bit code that indexes a fixed, non-uniform ratio table. Every legal ratio is 1, 2 or 3 times a power of two.

Software programs the four codes and a change-enable flag through a masked write port into one 32-bit control word, and reads the word back on a read port. Codes that are written while the flag is clear are stored but not used. While the flag is set, the stored codes are copied into the dividers only at a common alignment point. All counters wrap together at that point, so a ratio change never produces a short or stretched period in any domain.

Top module: `sysclk_ratio_div`

## Requirements
- R1: Codes 0 to 9 select the ratios 1, 2, 3, 4, 6, 8, 12, 16, 24 and 32 in that order. A domain's enable pulse then repeats every ratio input cycles.
- R2: Any code from 10 to 15 divides by 32, the same as code 9.
- R3: The control word carries the CPU code in bits 3:0, the high-speed bus code in bits 7:4, the low-speed bus code in bits 11:8 and the memory code in bits 15:12. These drive `tick_o[0]`, `tick_o[1]`, `tick_o[2]` and `tick_o[3]` in that order.
- R4: A write with `wr_en` high sets each control bit whose `wr_mask` bit is 1 to the matching `wr_data` bit and leaves every other bit unchanged. `rd_data` shows the result from the cycle after the write edge.
- R5: Bit 22 of the control word is the change-enable flag. While it is 0, writing new codes has no effect on any `tick_o` period.
- R6: An input-cycle counter runs from reset and wraps every 96 cycles. The alignment point is the cycle in which the counter holds 95, which means 95 edges after reset release modulo 96. While bit 22 is 1, the stored codes replace the active ratios at the clock edge that ends an alignment cycle. The old ratio holds up to and including that cycle.
- R7: All four enables are high together in every alignment cycle.
- R8: For ratios of 2 or more, each enable is high for exactly one input cycle per period. For ratio 1 it stays high.
- R9: After reset the control word reads 0, every domain divides by 1, and all four enables are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock from the PLL |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Write data |
| wr_mask | input | 32 | Per-bit write mask, 1 = bit is written |
| rd_data | output | 32 | Current control word |
| tick_o | output | 4 | Enables: CPU, high-speed bus, low-speed bus, memory |

## Verification
The bench builds the block with its default parameters: four domains, 4-bit codes, change-enable at bit 22 and an alignment period of 96. With a period that short, all sixteen codes, including the six saturating codes, can be swept on one domain in a few thousand cycles. The longest ratio of 32 repeats three times per alignment period, so the exact edge at which a new code takes over can be predicted from a plain cycle count since reset. The bench also sets four different ratios at once to confirm the field-to-output mapping, and checks that the enables coincide at alignment.

// File: rtl/sysdiv_pkg.sv
// Package: shared constants and the code-to-ratio decode for the system
// clock divider. Assumes codes are 4 bits and the largest ratio is 32.
package sysdiv_pkg;

    localparam int CODE_W    = 4;
    localparam int RATIO_MAX = 32;
    localparam int RATIO_W   = $clog2(RATIO_MAX) + 1;
    localparam int LAST_CODE = 9;

    // Map a ratio code to its divide factor: odd codes give powers of two,
    // even codes above zero give three times a power of two, and the high
    // codes saturate to the largest ratio.
    function automatic logic [RATIO_W-1:0] code_to_ratio(input logic [CODE_W-1:0] code);
        int unsigned sh;
        logic [RATIO_W-1:0] r;
        if (code == '0) begin
            r = RATIO_W'(1);
        end else if (int'(code) >= LAST_CODE) begin
            r = RATIO_W'(RATIO_MAX);
        end else if (code[0]) begin
            sh = (int'(code) + 1) >> 1;
            r  = RATIO_W'(1) << sh;
        end else begin
            sh = (int'(code) >> 1) - 1;
            r  = RATIO_W'(3) << sh;
        end
        return r;
    endfunction

endpackage

// File: rtl/sysdiv_ctrl_reg.sv
// Control word holder. A write replaces only the bits selected by the
// mask. Assumes a single writer; the word reads back without delay.
module sysdiv_ctrl_reg #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DATA_W-1:0] wr_mask,
    output logic [DATA_W-1:0] ctrl_q
);

    // Purpose: masked update of the control word, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_en) begin
            ctrl_q <= (ctrl_q & ~wr_mask) | (wr_data & wr_mask);
        end
    end

    assert_hold_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctrl_q));

    assert_unmasked_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((ctrl_q & ~$past(wr_mask)) == ($past(ctrl_q) & ~$past(wr_mask))));

endmodule

// File: rtl/sysdiv_align_cnt.sv
// Alignment counter. It runs freely from reset and flags the last cycle of
// each period. Assumes PERIOD is a common multiple of every table ratio, so
// every divider wraps in that same cycle.
module sysdiv_align_cnt #(
    parameter int PERIOD = 96
) (
    input  logic clk,
    input  logic rst_n,
    output logic align_o
);

    localparam int AW = $clog2(PERIOD);

    logic [AW-1:0] cnt_q;

    // Purpose: count input cycles modulo PERIOD.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (align_o) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + AW'(1);
        end
    end

    assign align_o = (cnt_q == AW'(PERIOD - 1));

    assert_align_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_q) < PERIOD);

endmodule

// File: rtl/sysdiv_channel.sv
// One divided domain. It holds an active ratio and a counter and raises a
// one-cycle enable each time the counter reaches ratio-1. A new ratio is
// taken only on load, which the top raises in an alignment cycle; every
// counter ends its period there, so all domains restart in phase.
module sysdiv_channel
    import sysdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              align,
    input  logic [CODE_W-1:0] code_next,
    output logic              tick
);

    logic [RATIO_W-1:0] ratio_q;
    logic [RATIO_W-1:0] cnt_q;

    // Purpose: hold the active ratio, replacing it only on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ratio_q <= RATIO_W'(1);
        end else if (load) begin
            ratio_q <= code_to_ratio(code_next);
        end
    end

    // Purpose: count input cycles within the current period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + RATIO_W'(1);
        end
    end

    assign tick = (cnt_q == RATIO_W'(ratio_q - RATIO_W'(1)));

    assert_coincident_at_align_R7: assert property (@(posedge clk) disable iff (!rst_n)
        align |-> tick);

    assert_ratio_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(ratio_q));

    assert_ratio_in_table_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_q inside {6'd1, 6'd2, 6'd3, 6'd4, 6'd6, 6'd8, 6'd12, 6'd16, 6'd24, 6'd32});

endmodule

// File: rtl/sysclk_ratio_div.sv
// Top of the encoded-ratio system clock divider. It stores the control
// word, runs the alignment counter and builds one divider channel per
// domain. Channel i takes its code from bits [i*CODE_W +: CODE_W].
// Assumes a single clock and that the change-enable bit lies outside the
// code fields.
module sysclk_ratio_div
    import sysdiv_pkg::*;
#(
    parameter int NUM_CLK      = 4,
    parameter int DATA_W       = 32,
    parameter int CHG_BIT      = 22,
    parameter int ALIGN_PERIOD = 96
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic [DATA_W-1:0]  wr_mask,
    output logic [DATA_W-1:0]  rd_data,
    output logic [NUM_CLK-1:0] tick_o
);

    logic [DATA_W-1:0] ctrl_q;
    logic              align;
    logic              load;

    sysdiv_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .wr_mask (wr_mask),
        .ctrl_q  (ctrl_q)
    );

    sysdiv_align_cnt #(.PERIOD(ALIGN_PERIOD)) u_align (
        .clk     (clk),
        .rst_n   (rst_n),
        .align_o (align)
    );

    // Purpose: copy stored codes only at alignment while change-enable is set.
    assign load    = align & ctrl_q[CHG_BIT];
    assign rd_data = ctrl_q;

    for (genvar i = 0; i < NUM_CLK; i++) begin : g_chan
        sysdiv_channel u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .load      (load),
            .align     (align),
            .code_next (ctrl_q[i*CODE_W +: CODE_W]),
            .tick      (tick_o[i])
        );
    end

    assert_reset_all_high_R9: assert property (@(posedge clk)
        !rst_n |=> (tick_o == '1));

endmodule

// File: tb/sysclk_ratio_div_bench.sv
module sysclk_ratio_div_bench;

    localparam int CLK_PERIOD = 10;
    localparam int CHG        = 22;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] wr_mask = '0;
    logic [31:0] rd_data;
    logic [3:0]  tick_o;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    int tbl [16] = '{1, 2, 3, 4, 6, 8, 12, 16, 24, 32, 32, 32, 32, 32, 32, 32};

    typedef struct {
        int    ch;
        int    ratio;
        string req;
    } exp_t;
    exp_t sbq[$];

    sysclk_ratio_div u_sysclk_ratio_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .wr_mask (wr_mask),
        .rd_data (rd_data),
        .tick_o  (tick_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Cycles since reset release; the design's alignment counter equals cyc % 96.
    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    task automatic chk(input string req, input int act, input int exp_v);
        n_chk++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    task automatic do_write(input logic [31:0] d, input logic [31:0] m);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d; wr_mask = m;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0; wr_mask = '0;
    endtask

    task automatic push_and_wait(input int ch, input int ratio, input string req);
        exp_t e;
        e.ch = ch; e.ratio = ratio; e.req = req;
        sbq.push_back(e);
        wait (sbq.size() == 0);
    endtask

    // Driver: program one code with change-enable, wait past alignment, expect the table ratio.
    task automatic apply(input int ch, input int code, input string req);
        do_write((32'(code) << (ch*4)) | (32'd1 << CHG), (32'hF << (ch*4)) | (32'd1 << CHG));
        repeat (200) @(negedge clk);
        push_and_wait(ch, tbl[code], req);
    endtask

    task automatic wait_phase(input int ph);
        @(negedge clk);
        while ((cyc % 96) != ph) @(negedge clk);
    endtask

    // Monitor: measure the spacing between enables on the requested channel.
    initial begin
        forever begin
            exp_t it;
            int   n;
            bit   low_after;
            wait (sbq.size() > 0);
            it = sbq[0];
            @(negedge clk);
            while (!tick_o[it.ch]) @(negedge clk);
            n = 0;
            low_after = 1'b0;
            do begin
                @(negedge clk);
                n++;
                if (n == 1) low_after = !tick_o[it.ch];
            end while (!tick_o[it.ch]);
            chk(it.req, n, it.ratio);
            if (it.ratio > 1) chk("R8 single-cycle pulse", int'(low_after), 1);
            sbq.delete(0);
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 reset control word", int'(rd_data), 0);
        chk("R9 reset enables", int'(tick_o), 4'hF);

        // R6: exact takeover edge, CPU code 0 -> 1 (ratio 1 -> 2)
        wait_phase(10);
        do_write(32'h1 | (32'd1 << CHG), 32'hF | (32'd1 << CHG));
        wait_phase(94);
        chk("R6 old ratio before alignment", int'(tick_o[0]), 1);
        @(negedge clk);
        chk("R7 all enables at alignment", int'(tick_o), 4'hF);
        @(negedge clk);
        chk("R6 new ratio after alignment", int'(tick_o[0]), 0);
        @(negedge clk);
        chk("R6 new ratio second cycle", int'(tick_o[0]), 1);

        // R1 / R2: sweep every code on the CPU domain
        for (int c = 0; c < 16; c++) begin
            apply(0, c, (c < 10) ? "R1 table ratio" : "R2 saturated ratio");
        end

        // R3: four different codes at once
        do_write(32'h2 | (32'h5 << 4) | (32'h8 << 8) | (32'hC << 12) | (32'd1 << CHG),
                 32'hFFFF | (32'd1 << CHG));
        repeat (200) @(negedge clk);
        push_and_wait(0, 3,  "R3 cpu field");
        push_and_wait(1, 8,  "R3 high-speed field");
        push_and_wait(2, 24, "R3 low-speed field");
        push_and_wait(3, 32, "R3 memory field");
        wait_phase(95);
        chk("R7 mixed ratios coincide", int'(tick_o), 4'hF);

        // R5: change-enable cleared, new CPU code must not take effect
        do_write(32'h9, 32'hF | (32'd1 << CHG));
        chk("R4 readback after code write", int'(rd_data), 32'h0000C859);
        repeat (200) @(negedge clk);
        push_and_wait(0, 3, "R5 code ignored while flag clear");

        // R4: masked write touches only selected bits
        do_write(32'hFFFF_FFFF, 32'h000F_0000);
        chk("R4 masked write", int'(rd_data), 32'h000F_C859);
        repeat (200) @(negedge clk);
        push_and_wait(0, 3, "R5 still ignored");

        // R5: setting the flag releases the stored code
        do_write(32'd1 << CHG, 32'd1 << CHG);
        chk("R4 flag set readback", int'(rd_data), 32'h004F_C859);
        repeat (200) @(negedge clk);
        push_and_wait(0, 32, "R5 code applied once flag set");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule